// File: doc/BRIEF.md
# Pin Port with Per-Pin Interrupt Detection

This block is a 32-pin general-purpose I/O port behind a simple word-wide register interface. Software sets an output value and a per-pin output enable, reads back the synchronized pin levels, and picks for each pin one of four triggers: low level, high level, rising edge or falling edge. A separate per-pin both-edges bit replaces the chosen trigger with "any change". Every detected event sets a sticky status bit. Software clears a status bit by writing 1 to it. A mask selects which status bits raise an interrupt.

The interrupt output is split by pin half. Pins 0 to 15 drive one request line and pins 16 to 31 drive another. Each pin input passes through a two-flop synchronizer before it is used for pad reads or detection. The previous synchronized value is kept so that edges can be detected. Register reads are combinational from the current address. Writes take effect at the clock edge where enable and write are both high.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset the output value, output enables, both trigger-mode words, the both-edges word and the mask all read zero. pin_out and pin_oe are zero and both request lines are low.
- R2: The output value register reads back what was written, and pin_out follows it. The direction register reads back what was written, and pin_oe follows it (1 means the pin is driven). Neither depends on pin_in.
- R3: The pad word returns pin_in delayed by two clock edges through the synchronizer. It is read-only: a write to it changes no register.
- R4: A pin's 2-bit trigger field sits at bits 2*(pin mod 16)+1:2*(pin mod 16). It is held in the word at 0x0C for pins 0 to 15 and in the word at 0x10 for pins 16 to 31. Encodings are 00 low level, 01 high level, 10 rising edge and 11 falling edge.
- R5: With a level trigger, the status bit is set again on every cycle that the level persists. A clear written while the level holds therefore leaves the bit set.
- R6: With an edge trigger, the status bit is set once per matching edge of the synchronized input. It is not set again while the level stays, and the opposite edge does not set it.
- R7: A 1 in the both-edges word at 0x1C makes that pin set its status bit on both rising and falling edges. The pin's 2-bit field has no effect while the bit is set.
- R8: Writing the status word at 0x18 clears each bit written as 1 and leaves each bit written as 0 unchanged. A new event in the same cycle as its clear leaves the bit set.
- R9: irq_lo is high exactly when some pin from 0 to 15 has both its status and mask bits set. irq_hi does the same for pins 16 to 31.
- R10: Byte offsets are: output value 0x00, direction 0x04, pad 0x08, trigger low half 0x0C, trigger high half 0x10, mask 0x14, status 0x18, both-edges 0x1C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 5 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| pin_in | input | 32 | Raw pin levels |
| pin_out | output | 32 | Driven pin values |
| pin_oe | output | 32 | Per-pin output enable |
| irq_lo | output | 1 | Request for pins 0 to 15 |
| irq_hi | output | 1 | Request for pins 16 to 31 |

## Verification
A software clear of a status bit and a fresh detection on the same pin can land in the same clock edge. The bench provokes this by raising a rising-edge pin, then issuing the clear so that it is sampled on the edge where the edge detector fires. The bit must still read 1 afterwards and must clear on a later write. The same rule is judged for level triggers by clearing while the level persists, where the bit must stay set.

// File: rtl/gpio_irq_port.sv
module gpio_irq_port #(
  parameter int NPINS       = 32,
  parameter int SYNC_STAGES = 2,
  parameter int AW          = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_en,
  input  logic             bus_we,
  input  logic [AW-1:0]    bus_addr,
  input  logic [NPINS-1:0] bus_wdata,
  output logic [NPINS-1:0] bus_rdata,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_oe,
  output logic             irq_lo,
  output logic             irq_hi
);
  localparam int HALF = NPINS / 2;
  localparam logic [2:0] W_DOUT  = 3'd0;
  localparam logic [2:0] W_DIR   = 3'd1;
  localparam logic [2:0] W_PAD   = 3'd2;
  localparam logic [2:0] W_TRLO  = 3'd3;
  localparam logic [2:0] W_TRHI  = 3'd4;
  localparam logic [2:0] W_MASK  = 3'd5;
  localparam logic [2:0] W_STAT  = 3'd6;
  localparam logic [2:0] W_BOTH  = 3'd7;

  logic [NPINS-1:0] dout_q, dir_q, trlo_q, trhi_q, mask_q, stat_q, both_q;
  logic [NPINS-1:0] sync_q [SYNC_STAGES];
  logic [NPINS-1:0] pad_q, prev_q, hit, clr;
  logic [2:0]       word;
  logic             wr;

  assign word = bus_addr[4:2];
  assign wr   = bus_en & bus_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q <= '0;
      dir_q  <= '0;
      trlo_q <= '0;
      trhi_q <= '0;
      mask_q <= '0;
      both_q <= '0;
    end else if (wr) begin
      case (word)
        W_DOUT: dout_q <= bus_wdata;
        W_DIR:  dir_q  <= bus_wdata;
        W_TRLO: trlo_q <= bus_wdata;
        W_TRHI: trhi_q <= bus_wdata;
        W_MASK: mask_q <= bus_wdata;
        W_BOTH: both_q <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q[0] <= '0;
    else        sync_q[0] <= pin_in;
  end

  for (genvar k = 1; k < SYNC_STAGES; k++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q[k] <= '0;
      else        sync_q[k] <= sync_q[k-1];
    end
  end

  assign pad_q = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= pad_q;
  end

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic [1:0] mode;
    logic       rise, fall;
    if (i < HALF) begin : g_lo
      assign mode = trlo_q[2*i +: 2];
    end else begin : g_hi
      assign mode = trhi_q[2*(i-HALF) +: 2];
    end
    assign rise = pad_q[i] & ~prev_q[i];
    assign fall = ~pad_q[i] & prev_q[i];
    assign hit[i] = both_q[i]     ? (rise | fall) :
                    (mode == 2'b00) ? ~pad_q[i] :
                    (mode == 2'b01) ?  pad_q[i] :
                    (mode == 2'b10) ?  rise : fall;
  end

  assign clr = (wr && word == W_STAT) ? bus_wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= (stat_q & ~clr) | hit;
  end

  always_comb begin
    case (word)
      W_DOUT:  bus_rdata = dout_q;
      W_DIR:   bus_rdata = dir_q;
      W_PAD:   bus_rdata = pad_q;
      W_TRLO:  bus_rdata = trlo_q;
      W_TRHI:  bus_rdata = trhi_q;
      W_MASK:  bus_rdata = mask_q;
      W_STAT:  bus_rdata = stat_q;
      default: bus_rdata = both_q;
    endcase
  end

  assign pin_out = dout_q;
  assign pin_oe  = dir_q;
  assign irq_lo  = |(stat_q[HALF-1:0] & mask_q[HALF-1:0]);
  assign irq_hi  = |(stat_q[NPINS-1:HALF] & mask_q[NPINS-1:HALF]);
endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk #(
  parameter int NPINS = 32,
  parameter int AW    = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_en,
  input logic             bus_we,
  input logic [AW-1:0]    bus_addr,
  input logic [NPINS-1:0] bus_wdata,
  input logic [NPINS-1:0] pin_in,
  input logic [NPINS-1:0] pad,
  input logic [NPINS-1:0] stat,
  input logic [NPINS-1:0] mask,
  input logic [NPINS-1:0] dout,
  input logic             irq_lo,
  input logic             irq_hi
);
  localparam int HALF = NPINS / 2;
  logic [1:0] cyc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cyc <= '0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;
  end

  p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == 2'd0) |-> (mask == '0 && dout == '0 && !irq_lo && !irq_hi));

  p_dout_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_we && bus_addr == 5'h00) |=> (dout == $past(bus_wdata)));

  p_pad_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 2'd2) |-> (pad == $past(pin_in, 2)));

  p_stat_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_en && bus_we && bus_addr == 5'h18) |=> ((stat & $past(stat)) == $past(stat)));

  p_lo_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mask[HALF-1:0] == '0) |-> !irq_lo);

  p_hi_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mask[NPINS-1:HALF] == '0) |-> !irq_hi);
endmodule

bind gpio_irq_port gpio_irq_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .pin_in(pin_in),
  .pad(pad_q), .stat(stat_q), .mask(mask_q), .dout(dout_q),
  .irq_lo(irq_lo), .irq_hi(irq_hi)
);

// File: tb/test_gpio_irq_port.sv
`timescale 1ns/1ps
module test_gpio_irq_port;
  localparam logic [4:0] A_DOUT = 5'h00, A_DIR = 5'h04, A_PAD = 5'h08,
                         A_TRLO = 5'h0C, A_TRHI = 5'h10, A_MASK = 5'h14,
                         A_STAT = 5'h18, A_BOTH = 5'h1C;

  logic        clk = 0, rst_n = 0;
  logic        bus_en = 0, bus_we = 0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata, pin_in = '0, pin_out, pin_oe;
  logic        irq_lo, irq_hi;
  int          n_chk = 0, n_bad = 0;
  bit          done = 0;

  always #4 clk = ~clk;

  gpio_irq_port i_gpio_irq_port (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .irq_lo(irq_lo), .irq_hi(irq_hi));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_en = 1; bus_we = 1;
    @(negedge clk);
    bus_en = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_addr = a; bus_en = 1; bus_we = 0;
    #1 d = bus_rdata;
    bus_en = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(A_DOUT, v); chk("R1 dout", v, 0);
    rd(A_DIR,  v); chk("R1 dir", v, 0);
    rd(A_TRLO, v); chk("R1 trlo", v, 0);
    rd(A_TRHI, v); chk("R1 trhi", v, 0);
    rd(A_MASK, v); chk("R1 mask", v, 0);
    rd(A_BOTH, v); chk("R1 both", v, 0);
    chk("R1 pins", {pin_out ^ pin_oe}, 0);
    chk("R1 irq", {30'd0, irq_hi, irq_lo}, 0);
  endtask

  task automatic t_data_dir();
    logic [31:0] v;
    pin_in = 32'h1234_5678;
    wr(A_DOUT, 32'hA5A5_0F0F);
    wr(A_DIR,  32'hFFFF_0000);
    rd(A_DOUT, v); chk("R2 R10 dout readback", v, 32'hA5A5_0F0F);
    rd(A_DIR,  v); chk("R2 R10 dir readback", v, 32'hFFFF_0000);
    chk("R2 pin_out", pin_out, 32'hA5A5_0F0F);
    chk("R2 pin_oe", pin_oe, 32'hFFFF_0000);
  endtask

  task automatic t_pad();
    logic [31:0] v;
    idle(2);
    rd(A_PAD, v); chk("R3 pad settled", v, 32'h1234_5678);
    pin_in = 32'h0F0F_F0F0;
    idle(1);
    rd(A_PAD, v); chk("R3 pad one edge", v, 32'h1234_5678);
    idle(1);
    rd(A_PAD, v); chk("R3 pad two edges", v, 32'h0F0F_F0F0);
    wr(A_PAD, 32'hFFFF_FFFF);
    rd(A_PAD, v); chk("R3 pad write ignored", v, 32'h0F0F_F0F0);
    rd(A_DOUT, v); chk("R3 dout untouched", v, 32'hA5A5_0F0F);
    rd(A_DIR, v);  chk("R3 dir untouched", v, 32'hFFFF_0000);
    pin_in = '0;
    idle(3);
  endtask

  task automatic t_level();
    logic [31:0] v;
    wr(A_TRLO, 32'h0000_0400);
    wr(A_STAT, 32'h0000_0060);
    rd(A_STAT, v); chk("R4 high-level pin5 idle", v[5], 0);
    chk("R4 R5 low-level pin6 refires", v[6], 1);
    pin_in[5] = 1;
    idle(3);
    rd(A_STAT, v); chk("R4 high-level pin5 set", v[5], 1);
    wr(A_STAT, 32'h0000_0020);
    rd(A_STAT, v); chk("R5 level persists after clear", v[5], 1);
    pin_in[5] = 0;
    idle(3);
    wr(A_STAT, 32'h0000_0020);
    rd(A_STAT, v); chk("R5 clear after level gone", v[5], 0);
  endtask

  task automatic t_edge();
    logic [31:0] v;
    wr(A_TRHI, 32'h0000_0E00);
    wr(A_STAT, 32'h0030_0000);
    rd(A_STAT, v); chk("R6 no edge yet", v[21:20], 0);
    pin_in[21:20] = 2'b11;
    idle(3);
    rd(A_STAT, v); chk("R4 R6 rising pin20 set, falling pin21 not", v[21:20], 2'b01);
    wr(A_STAT, 32'h0010_0000);
    rd(A_STAT, v); chk("R6 no refire while high", v[20], 0);
    pin_in[21:20] = 2'b00;
    idle(3);
    rd(A_STAT, v); chk("R4 R6 falling pin21 set, rising pin20 not", v[21:20], 2'b10);
  endtask

  task automatic t_irq();
    wr(A_MASK, 32'h0020_0000);
    chk("R9 hi line only", {30'd0, irq_hi, irq_lo}, 2'b10);
    wr(A_MASK, 32'h0000_0020);
    chk("R9 masked clear bit no request", {30'd0, irq_hi, irq_lo}, 2'b00);
    wr(A_MASK, 32'h0000_0040);
    chk("R9 lo line only", {30'd0, irq_hi, irq_lo}, 2'b01);
    wr(A_MASK, 32'h0000_0000);
    chk("R9 all masked", {30'd0, irq_hi, irq_lo}, 2'b00);
  endtask

  task automatic t_w1c();
    logic [31:0] v;
    wr(A_STAT, 32'h0000_0000);
    rd(A_STAT, v); chk("R8 zero write keeps bit", v[21], 1);
    wr(A_STAT, 32'hFFFF_FFFF);
    rd(A_STAT, v); chk("R8 all-ones clears edge bit", v[21], 0);
    chk("R8 R5 level bit set again", v[6], 1);
  endtask

  task automatic t_both();
    logic [31:0] v;
    wr(A_BOTH, 32'h0000_0008);
    rd(A_BOTH, v); chk("R7 R10 both readback", v, 32'h0000_0008);
    wr(A_STAT, 32'h0000_0008);
    rd(A_STAT, v); chk("R7 low-level field ignored", v[3], 0);
    pin_in[3] = 1;
    idle(3);
    rd(A_STAT, v); chk("R7 rising sets", v[3], 1);
    wr(A_STAT, 32'h0000_0008);
    rd(A_STAT, v); chk("R7 cleared while high", v[3], 0);
    pin_in[3] = 0;
    idle(3);
    rd(A_STAT, v); chk("R7 falling sets", v[3], 1);
  endtask

  task automatic t_collide();
    logic [31:0] v;
    wr(A_TRLO, 32'h0000_8400);
    wr(A_STAT, 32'h0000_0080);
    rd(A_STAT, v); chk("R8 pin7 clear before race", v[7], 0);
    pin_in[7] = 1;
    idle(2);
    wr(A_STAT, 32'h0000_0080);
    rd(A_STAT, v); chk("R8 event wins over same-edge clear", v[7], 1);
    wr(A_STAT, 32'h0000_0080);
    rd(A_STAT, v); chk("R8 later clear works", v[7], 0);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1;
    t_reset();
    idle(1);
    t_data_dir();
    t_pad();
    t_level();
    t_edge();
    t_irq();
    t_w1c();
    t_both();
    t_collide();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule